// File: doc/BRIEF.md
# Parallel RGB Display Output Formatter

The formatter sits between a pixel timing generator and a parallel RGB panel bus. On every pixel-clock cycle it accepts a 24-bit pixel plus horizontal sync, vertical sync and data-enable. It rearranges the three colour channels, fits the result into one of several output bit layouts, and conditions each control line. Each control line can be inverted, launched on the falling clock edge, or forced to its idle level. A forwarded pixel clock can also be inverted.

One 32-bit control word sets all of this through a small register port. The word lives at address 0x00, and every other address reads back a fixed identification constant. Bit 0 of the control word gates the whole datapath. While it is clear, every output stays low. When it is set again, the pipeline is flushed for one cycle before new pixels reach the bus.

Top module: `rgb_panel_fmt`

## Requirements
- R1: After a cycle with `rst_n` low, the control word is zero and `out_data`, `out_hsync`, `out_vsync`, `out_oe` and `out_pclk` are all low.
- R2: With `reg_addr` equal to 0x00, `reg_rdata` returns the control word in bits 16:0 with zeros above. Any other address returns 0x00647069.
- R3: A write to any address other than 0x00 leaves the control word and the output stream unchanged.
- R4: While control bit 0 (enable) is clear, all outputs are low and pixel inputs have no effect. When bit 0 is cleared, the outputs are low after the next rising edge.
- R5: When bit 0 goes from 0 to 1, the first rising edge after the write captures zeros on every output. The pixel present at the following edge is the first to appear.
- R6: A pixel and its syncs present before a rising edge appear on `out_data` and on the rising-edge-mode control lines just after that edge. This is one cycle of latency.
- R7: Bits 15:14 pick the channel order, with the input split as red = `pix_rgb[23:16]`, green = `[15:8]` and blue = `[7:0]`. The codes map to output slots as follows: 0 gives R,G,B; 1 gives B,G,R; 2 gives G,R,B; 3 gives B,R,G. Slot one is the first channel used by the layout.
- R8: Bits 13:11 pick the layout, using the top bits of each slot (s1, s2, s3). Code 1 is 8 zeros, then s1[7:3], s2[7:2], s3[7:3]. Code 2 is 3 zeros, s1[7:3], 2 zeros, s2[7:2], 3 zeros, s3[7:3]. Code 3 is 2 zeros, s1[7:3], 3 zeros, s2[7:2], 2 zeros, s3[7:3], 1 zero. All layouts are listed MSB first.
- R9: Layout code 4 is 6 zeros, then s1[7:2], s2[7:2], s3[7:2]. Code 5 is 2 zeros, s1[7:2], 2 zeros, s2[7:2], 2 zeros, s3[7:2]. Code 6 is s1, s2, s3 at full width. Codes 0 and 7 drive all zeros.
- R10: Bits 9, 8 and 7 invert hsync, vsync and output-enable respectively; the input lines are active high. Bit 10 inverts `out_pclk` relative to `clk`.
- R11: Bits 6, 5 and 4 make hsync, vsync and output-enable respectively change half a cycle later, at the falling edge that follows the capturing rising edge.
- R12: Bits 3, 2 and 1 force hsync, vsync and output-enable respectively to their idle level. The idle level is the value of that line's invert bit.
- R13: With bit 16 set, `out_oe` carries `pix_de`. With it clear, `out_oe` stays at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| pix_rgb | input | 24 | Incoming pixel, red in the top byte |
| pix_hsync | input | 1 | Incoming horizontal sync, active high |
| pix_vsync | input | 1 | Incoming vertical sync, active high |
| pix_de | input | 1 | Incoming data-enable, active high |
| out_pclk | output | 1 | Forwarded pixel clock |
| out_data | output | 24 | Packed panel data |
| out_hsync | output | 1 | Conditioned horizontal sync |
| out_vsync | output | 1 | Conditioned vertical sync |
| out_oe | output | 1 | Conditioned output-enable |

## Verification
The enable flush and pixel capture can fall on the same edge. This happens when a nonzero pixel with all syncs active is already on the inputs at the moment enable is written to 1. The bench requires zeros on every line after the first edge and the held pixel after the second. A second collision is a layout or order change written on the same edge that captures a pixel. The bench therefore judges each reordered or repacked word against the control value in force at the capturing edge. Falling-edge launch is judged by sampling the same transition in both clock phases.

// File: rtl/rgbfmt_pkg.sv
`timescale 1ns/1ps
// Shared widths, control-word layout and code values for the RGB formatter.
package rgbfmt_pkg;
    localparam int CH_W    = 8;
    localparam int PIX_W   = 3 * CH_W;
    localparam int REG_W   = 32;
    localparam int CTRL_W  = 17;
    localparam int SIG_N   = 3;
    localparam int NARROW  = CH_W - 3;   // 5-bit channel width
    localparam int MEDIUM  = CH_W - 2;   // 6-bit channel width
    localparam logic [REG_W-1:0] ID_WORD = 32'h0064_7069;

    // Control line indices inside the conditioning vectors
    localparam int SIG_HS = 0;
    localparam int SIG_VS = 1;
    localparam int SIG_OE = 2;

    typedef enum logic [1:0] {
        ORD_RGB = 2'd0,
        ORD_BGR = 2'd1,
        ORD_GRB = 2'd2,
        ORD_BRG = 2'd3
    } chan_order_e;

    typedef enum logic [2:0] {
        LAY_ZERO       = 3'd0,
        LAY_565_LOW    = 3'd1,
        LAY_565_SPREAD = 3'd2,
        LAY_565_SHIFT  = 3'd3,
        LAY_666_LOW    = 3'd4,
        LAY_666_SPREAD = 3'd5,
        LAY_888        = 3'd6,
        LAY_SPARE      = 3'd7
    } layout_e;

    // Control word, MSB first; bit positions are decoded by software
    typedef struct packed {
        logic        oe_mode;   // 16
        chan_order_e order;     // 15:14
        layout_e     layout;    // 13:11
        logic        pclk_inv;  // 10
        logic        hs_inv;    // 9
        logic        vs_inv;    // 8
        logic        oe_inv;    // 7
        logic        hs_fall;   // 6
        logic        vs_fall;   // 5
        logic        oe_fall;   // 4
        logic        hs_off;    // 3
        logic        vs_off;    // 2
        logic        oe_off;    // 1
        logic        enable;    // 0
    } fmt_ctrl_t;
endpackage

// File: rtl/rgbfmt_regs.sv
`timescale 1ns/1ps
// Control register and read mux.
// Holds the 17-bit control word at address zero. Every other address
// reads the identification constant and ignores writes.
// Assumes single-cycle write strobes; reads are combinational.
module rgbfmt_regs
    import rgbfmt_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [REG_W-1:0] ID_VALUE = ID_WORD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output fmt_ctrl_t         ctrl,
    output logic [REG_W-1:0]  rdata
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = '0;
    localparam int                PAD_W     = REG_W - CTRL_W;

    logic sel_ctrl;
    assign sel_ctrl = (addr == CTRL_ADDR);

    // Capture the control word on a write to address zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl <= '0;
        else if (wr_en && sel_ctrl)
            ctrl <= fmt_ctrl_t'(wdata[CTRL_W-1:0]);
    end

    // Return the control word or the identification constant
    always_comb begin
        if (sel_ctrl)
            rdata = {{PAD_W{1'b0}}, ctrl};
        else
            rdata = ID_VALUE;
    end

    assert_foreign_write_ignored_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_ctrl) |=> $stable(ctrl)
    );
endmodule

// File: rtl/rgbfmt_swizzle.sv
`timescale 1ns/1ps
// Channel permutation.
// Splits the pixel into red, green and blue bytes and places them into
// three ordered slots. The layout stage reads the slots as first, second
// and third. Purely combinational.
module rgbfmt_swizzle
    import rgbfmt_pkg::*;
(
    input  logic [PIX_W-1:0] pix,
    input  chan_order_e      order,
    output logic [PIX_W-1:0] slots
);
    logic [CH_W-1:0] red, grn, blu;

    assign red = pix[3*CH_W-1:2*CH_W];
    assign grn = pix[2*CH_W-1:CH_W];
    assign blu = pix[CH_W-1:0];

    // Pick the slot order from the order code
    always_comb begin
        unique case (order)
            ORD_RGB: slots = {red, grn, blu};
            ORD_BGR: slots = {blu, grn, red};
            ORD_GRB: slots = {grn, red, blu};
            ORD_BRG: slots = {blu, red, grn};
            default: slots = {red, grn, blu};
        endcase
    end
endmodule

// File: rtl/rgbfmt_pack.sv
`timescale 1ns/1ps
// Bus layout packer.
// Truncates the three slots to 5, 6 or 8 bits and places them, with
// zero padding, in the selected 24-bit bus layout. Layout codes 0 and 7
// produce all zeros. Purely combinational.
module rgbfmt_pack
    import rgbfmt_pkg::*;
(
    input  logic [PIX_W-1:0] slots,
    input  layout_e          layout,
    output logic [PIX_W-1:0] word
);
    logic [CH_W-1:0]   s1, s2, s3;
    logic [NARROW-1:0] s1_n, s3_n;
    logic [MEDIUM-1:0] s1_m, s2_m, s3_m;

    assign s1   = slots[3*CH_W-1:2*CH_W];
    assign s2   = slots[2*CH_W-1:CH_W];
    assign s3   = slots[CH_W-1:0];
    assign s1_n = s1[CH_W-1 -: NARROW];
    assign s3_n = s3[CH_W-1 -: NARROW];
    assign s1_m = s1[CH_W-1 -: MEDIUM];
    assign s2_m = s2[CH_W-1 -: MEDIUM];
    assign s3_m = s3[CH_W-1 -: MEDIUM];

    // Build the bus word for the selected layout
    always_comb begin
        unique case (layout)
            LAY_565_LOW:    word = {8'b0, s1_n, s2_m, s3_n};
            LAY_565_SPREAD: word = {3'b0, s1_n, 2'b0, s2_m, 3'b0, s3_n};
            LAY_565_SHIFT:  word = {2'b0, s1_n, 3'b0, s2_m, 2'b0, s3_n, 1'b0};
            LAY_666_LOW:    word = {6'b0, s1_m, s2_m, s3_m};
            LAY_666_SPREAD: word = {2'b0, s1_m, 2'b0, s2_m, 2'b0, s3_m};
            LAY_888:        word = {s1, s2, s3};
            default:        word = '0;
        endcase
    end
endmodule

// File: rtl/rgbfmt_sync_stage.sv
`timescale 1ns/1ps
// Control-line conditioning with selectable launch edge.
// Each line is inverted or forced idle, then registered on the rising
// edge. A copy is re-registered on the falling edge, and a per-line select
// picks which copy drives the pin. Both copies clear while hold is high.
// Assumes hold comes from the rising-edge domain and is stable at the
// falling edge.
module rgbfmt_sync_stage
    import rgbfmt_pkg::*;
#(
    parameter int LINES = SIG_N
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic [LINES-1:0] act,
    input  logic [LINES-1:0] inv,
    input  logic [LINES-1:0] off,
    input  logic [LINES-1:0] fall,
    output logic [LINES-1:0] lvl
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic rise_q;
        logic fall_q;

        // Rising-edge launch: invert or force idle, then register
        always_ff @(posedge clk) begin
            if (!rst_n || hold)
                rise_q <= 1'b0;
            else if (off[i])
                rise_q <= inv[i];
            else
                rise_q <= act[i] ^ inv[i];
        end

        // Falling-edge launch: half-cycle delayed copy
        always_ff @(negedge clk) begin
            if (!rst_n || hold)
                fall_q <= 1'b0;
            else
                fall_q <= rise_q;
        end

        assign lvl[i] = fall[i] ? fall_q : rise_q;

        assert_forced_idle_R12: assert property (
            @(posedge clk) disable iff (!rst_n)
            (off[i] && !hold) |=> (rise_q == $past(inv[i]))
        );
    end
endmodule

// File: rtl/rgb_panel_fmt.sv
`timescale 1ns/1ps
// Parallel RGB display output formatter (top).
// Reorders and packs each pixel, conditions the three control lines and
// forwards the pixel clock. Everything is configured by one control word.
// Bit 0 of the control word gates the datapath. While it is clear, or on
// the first edge after it is set, every pipeline register is held at zero.
// Assumes all inputs are synchronous to clk.
module rgb_panel_fmt
    import rgbfmt_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [23:0]       pix_rgb,
    input  logic              pix_hsync,
    input  logic              pix_vsync,
    input  logic              pix_de,
    output logic              out_pclk,
    output logic [23:0]       out_data,
    output logic              out_hsync,
    output logic              out_vsync,
    output logic              out_oe
);
    fmt_ctrl_t        ctrl;
    logic             en_q;
    logic             hold;
    logic [PIX_W-1:0] slots;
    logic [PIX_W-1:0] word;
    logic [PIX_W-1:0] data_q;
    logic [SIG_N-1:0] act, inv, off, fall, lvl;

    rgbfmt_regs #(
        .ADDR_W   (ADDR_W),
        .ID_VALUE (ID_WORD)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr_en),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .ctrl  (ctrl),
        .rdata (reg_rdata)
    );

    rgbfmt_swizzle u_swizzle (
        .pix   (pix_rgb),
        .order (ctrl.order),
        .slots (slots)
    );

    rgbfmt_pack u_pack (
        .slots  (slots),
        .layout (ctrl.layout),
        .word   (word)
    );

    // Remember last cycle's enable so its rising edge can flush the pipe
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else
            en_q <= ctrl.enable;
    end

    assign hold = !ctrl.enable || !en_q;

    // Register the packed pixel, cleared while held
    always_ff @(posedge clk) begin
        if (!rst_n || hold)
            data_q <= '0;
        else
            data_q <= word;
    end

    // Gather per-line controls into vectors indexed by line
    always_comb begin
        act[SIG_HS]  = pix_hsync;
        act[SIG_VS]  = pix_vsync;
        act[SIG_OE]  = ctrl.oe_mode & pix_de;
        inv[SIG_HS]  = ctrl.hs_inv;
        inv[SIG_VS]  = ctrl.vs_inv;
        inv[SIG_OE]  = ctrl.oe_inv;
        off[SIG_HS]  = ctrl.hs_off;
        off[SIG_VS]  = ctrl.vs_off;
        off[SIG_OE]  = ctrl.oe_off | ~ctrl.oe_mode;
        fall[SIG_HS] = ctrl.hs_fall;
        fall[SIG_VS] = ctrl.vs_fall;
        fall[SIG_OE] = ctrl.oe_fall;
    end

    rgbfmt_sync_stage #(
        .LINES (SIG_N)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (hold),
        .act   (act),
        .inv   (inv),
        .off   (off),
        .fall  (fall),
        .lvl   (lvl)
    );

    assign out_data  = data_q;
    assign out_hsync = lvl[SIG_HS];
    assign out_vsync = lvl[SIG_VS];
    assign out_oe    = lvl[SIG_OE];
    assign out_pclk  = ctrl.enable & (clk ^ ctrl.pclk_inv);

    assert_gated_low_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        !ctrl.enable |=> (out_data == '0 && !out_hsync && !out_vsync && !out_oe)
    );

    assert_enable_flush_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
        $rose(ctrl.enable) |=> (out_data == '0)
    );

    assert_zero_layout_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ctrl.layout == LAY_ZERO || ctrl.layout == LAY_SPARE) |=> (out_data == '0)
    );
endmodule

// File: tb/rgb_panel_fmt_bench.sv
`timescale 1ns/1ps
module rgb_panel_fmt_bench;
    localparam int ADDR_W = 8;
    localparam logic [31:0] ID_EXP = 32'h0064_7069;
    localparam int EN = 1, OEM = 1 << 16, PCLK_I = 1 << 10;
    localparam int HS_I = 1 << 9, VS_I = 1 << 8, OE_I = 1 << 7;
    localparam int HS_F = 1 << 6, VS_F = 1 << 5, OE_F = 1 << 4;
    localparam int HS_D = 1 << 3, VS_D = 1 << 2, OE_D = 1 << 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [23:0] pix_rgb = '0;
    logic pix_hsync = 1'b0, pix_vsync = 1'b0, pix_de = 1'b0;
    logic out_pclk, out_hsync, out_vsync, out_oe;
    logic [23:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rgb_panel_fmt #(.ADDR_W(ADDR_W)) u_rgb_panel_fmt (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_rgb(pix_rgb),
        .pix_hsync(pix_hsync), .pix_vsync(pix_vsync), .pix_de(pix_de),
        .out_pclk(out_pclk), .out_data(out_data), .out_hsync(out_hsync),
        .out_vsync(out_vsync), .out_oe(out_oe)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int cw(int ord, int lay, int extra);
        return (ord << 14) | (lay << 11) | extra | EN;
    endfunction

    // Reference packing written from the layout requirements
    function automatic logic [23:0] model(logic [23:0] px, int ord, int lay);
        int r = px[23:16], g = px[15:8], b = px[7:0];
        int a, m, c, w;
        case (ord)
            0: begin a = r; m = g; c = b; end
            1: begin a = b; m = g; c = r; end
            2: begin a = g; m = r; c = b; end
            default: begin a = b; m = r; c = g; end
        endcase
        case (lay)
            1: w = ((a >> 3) << 11) | ((m >> 2) << 5) | (c >> 3);
            2: w = ((a >> 3) << 16) | ((m >> 2) << 8) | (c >> 3);
            3: w = ((a >> 3) << 17) | ((m >> 2) << 8) | ((c >> 3) << 1);
            4: w = ((a >> 2) << 12) | ((m >> 2) << 6) | (c >> 2);
            5: w = ((a >> 2) << 16) | ((m >> 2) << 8) | (c >> 2);
            6: w = (a << 16) | (m << 8) | c;
            default: w = 0;
        endcase
        return w[23:0];
    endfunction

    task automatic wr(int addr, int data);
        @(negedge clk); #1;
        reg_wr_en = 1'b1; reg_addr = addr[ADDR_W-1:0]; reg_wdata = data;
        @(posedge clk); #1;
        reg_wr_en = 1'b0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic rd(int addr, output logic [31:0] val);
        reg_addr = addr[ADDR_W-1:0];
        #0.2;
        val = reg_rdata;
        reg_addr = '0;
    endtask

    task automatic set_pix(logic [23:0] px, logic h, logic v, logic d);
        @(negedge clk); #1;
        pix_rgb = px; pix_hsync = h; pix_vsync = v; pix_de = d;
    endtask

    // Drive a pixel and stop just after the capturing rising edge
    task automatic step(logic [23:0] px, logic h, logic v, logic d);
        set_pix(px, h, v, d);
        @(posedge clk); #1;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        chk("R1 data", out_data, 0);
        chk("R1 syncs", {out_hsync, out_vsync, out_oe}, 0);
        chk("R1 pclk", out_pclk, 0);
        rd(0, v);   chk("R1 ctrl", v, 0);
        rd(4, v);   chk("R2 id@04", v, ID_EXP);
        rd(8'hFC, v); chk("R2 id@fc", v, ID_EXP);
    endtask

    task automatic t_disabled;
        step(24'hFFFFFF, 1, 1, 1);
        chk("R4 data", out_data, 0);
        chk("R4 syncs", {out_hsync, out_vsync, out_oe}, 0);
        chk("R4 pclk high phase", out_pclk, 0);
        @(negedge clk); #1;
        chk("R4 pclk low phase", out_pclk, 0);
    endtask

    task automatic t_enable_flush;
        set_pix(24'h123456, 1, 1, 1);
        wr(0, cw(0, 6, OEM));
        @(posedge clk); #1;
        chk("R5 flush data", out_data, 0);
        chk("R5 flush syncs", {out_hsync, out_vsync, out_oe}, 0);
        @(posedge clk); #1;
        chk("R5 first pixel", out_data, 24'h123456);
        chk("R5 first syncs", {out_hsync, out_vsync, out_oe}, 3'b111);
        chk("R10 pclk follows clk", out_pclk, 1);
    endtask

    task automatic t_latency;
        set_pix(24'hABCDEF, 0, 1, 0);
        chk("R6 before edge", out_data, 24'h123456);
        @(posedge clk); #1;
        chk("R6 after edge", out_data, 24'hABCDEF);
        chk("R6 syncs", {out_hsync, out_vsync, out_oe}, 3'b010);
    endtask

    task automatic t_orders;
        for (int o = 1; o < 4; o++) begin
            wr(0, cw(o, 6, OEM));
            step(24'h11_22_33, 0, 0, 1);
            chk($sformatf("R7 order %0d", o), out_data, model(24'h112233, o, 6));
        end
    endtask

    task automatic t_layouts;
        for (int l = 0; l < 8; l++) begin
            wr(0, cw(2, l, OEM));
            step(24'hA5_3C_F1, 0, 0, 1);
            if (l >= 1 && l <= 3)
                chk($sformatf("R8 layout %0d", l), out_data, model(24'hA53CF1, 2, l));
            else
                chk($sformatf("R9 layout %0d", l), out_data, model(24'hA53CF1, 2, l));
        end
    endtask

    task automatic t_invert;
        wr(0, cw(0, 6, OEM | HS_I | VS_I | OE_I | PCLK_I));
        step(24'h0, 0, 0, 0);
        chk("R10 idle inverted", {out_hsync, out_vsync, out_oe}, 3'b111);
        chk("R10 pclk high phase", out_pclk, 0);
        step(24'h0, 1, 1, 1);
        chk("R10 active inverted", {out_hsync, out_vsync, out_oe}, 3'b000);
        @(negedge clk); #1;
        chk("R10 pclk low phase", out_pclk, 1);
    endtask

    task automatic t_force_idle;
        wr(0, cw(0, 6, OEM | HS_D | VS_D | OE_D | VS_I));
        step(24'h0, 1, 1, 1);
        chk("R12 forced idle", {out_hsync, out_vsync, out_oe}, 3'b010);
    endtask

    task automatic t_oe_mode;
        wr(0, cw(0, 6, 0));
        step(24'h0, 0, 0, 1);
        chk("R13 mode off", out_oe, 0);
        wr(0, cw(0, 6, OE_I));
        step(24'h0, 0, 0, 1);
        chk("R13 mode off inverted", out_oe, 1);
        wr(0, cw(0, 6, OEM));
        step(24'h0, 0, 0, 1);
        chk("R13 mode on", out_oe, 1);
    endtask

    task automatic t_falling;
        wr(0, cw(0, 6, OEM | HS_F | OE_F));
        step(24'h0, 0, 0, 0);
        @(negedge clk); #1;
        step(24'h0, 1, 1, 1);
        chk("R11 rising half", {out_hsync, out_vsync, out_oe}, 3'b010);
        @(negedge clk); #1;
        chk("R11 falling half", {out_hsync, out_vsync, out_oe}, 3'b111);
    endtask

    task automatic t_foreign_write;
        logic [31:0] v;
        wr(0, cw(1, 6, OEM));
        wr(4, 0);
        rd(0, v);
        chk("R3 ctrl kept", v, cw(1, 6, OEM));
        step(24'h0A_0B_0C, 0, 0, 1);
        chk("R3 stream kept", out_data, model(24'h0A0B0C, 1, 6));
    endtask

    task automatic t_disable_again;
        logic [31:0] v;
        wr(0, 0);
        step(24'h777777, 1, 1, 1);
        chk("R4 cleared data", out_data, 0);
        chk("R4 cleared syncs", {out_hsync, out_vsync, out_oe}, 0);
        chk("R4 cleared pclk", out_pclk, 0);
        wr(0, 32'hFFFF_FFFF);
        rd(0, v);
        chk("R2 ctrl mask", v, 32'h0001_FFFF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_disabled();
        t_enable_flush();
        t_latency();
        t_orders();
        t_layouts();
        t_invert();
        t_force_idle();
        t_oe_mode();
        t_falling();
        t_foreign_write();
        t_disable_again();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule